// File: doc/BRIEF.md
# Serial-to-Parallel Word Converter with Diagnostic Loopback

This block takes a serial bit stream, sampled on its bit clock, and packs every sixteen consecutive bits into one parallel word. It divides the bit clock by sixteen to produce a word clock, and the parallel output changes only on that clock's rising edge. A static configuration pin selects which edge of the output word receives the first bit of each group. A fixed pipeline of five word periods separates the last serial bit of a word from its appearance at the output.

For diagnostics, the parallel output can be taken from the local transmit-side parallel word instead of the deserialized stream. The substitution is enabled by one encoding of three control fields only. A control change is sampled at the word clock's rising edge, so the output never carries a mixture of two sources. The output stream runs at a fixed rate and has no valid or ready signal. Each word clock period carries exactly one word, and downstream logic cannot apply back-pressure. It must accept a word on every rising edge of the word clock.

Top module: `deser16_lb`

## Requirements
- R1: `word_clk` is the bit clock divided by 16 with a 50% duty cycle. After reset it is low for the first 8 bit clocks and high for the next 8.
- R2: With `msb_first` = 1, the first serial bit of a group of 16 appears on `rx_word[15]` and the last on `rx_word[0]`.
- R3: With `msb_first` = 0, the first serial bit of a group appears on `rx_word[0]` and the last on `rx_word[15]`.
- R4: `rx_word` changes only on a bit clock edge at which `word_clk` rises.
- R5: The group whose bits arrive in word period k (bits 16k to 16k+15 after reset, counting from 0) appears on `rx_word` at the `word_clk` rising edge of word period k+5.
- R6: In loopback, the `rx_word` loaded at a `word_clk` rising edge equals `tx_word` at that edge, with bit positions unchanged.
- R7: Loopback is selected only when `bist_en_n` = 0, `lpbk_en_n` = 0 and `lpbk_sel` = 2'b10. Every other combination delivers the deserialized data.
- R8: A control change made between rising edges of `word_clk` does not alter `rx_word` before the next rising edge.
- R9: While reset is asserted, `rx_word` is zero and `word_clk` is low. After reset, `rx_word` stays zero in normal mode until the first group completes the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_din | input | 1 | Serial data bit, sampled on the rising edge of `clk_bit` |
| msb_first | input | 1 | Bit-order select: 1 puts the first bit on bit 15, 0 puts it on bit 0 |
| tx_word | input | 16 | Local transmit-side parallel word, used as the loopback source |
| bist_en_n | input | 1 | Self-test enable, active low (one of the loopback qualifiers) |
| lpbk_en_n | input | 1 | Loopback enable, active low |
| lpbk_sel | input | 2 | Test-mode select; 2'b10 is the parallel loopback code |
| rx_word | output | 16 | Parallel output word, updated on the rising edge of `word_clk` |
| word_clk | output | 1 | Word clock, bit clock divided by 16 |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a latency of five word periods. These values cover the full divide-by-16 framing, both bit orders on alternating groups, and the exact cycle at which each group surfaces behind five zero words after reset. The same build is used to drive all four control encodings around the loopback code, to change the controls part-way through a word period, and to assert reset in the middle of the stream.

// File: rtl/deser16_pkg.sv
package deser16_pkg;

  typedef enum logic [1:0] {
    TSEL_NONE    = 2'b00,
    TSEL_SERIAL  = 2'b01,
    TSEL_PARLOOP = 2'b10,
    TSEL_RSVD    = 2'b11
  } tsel_e;

  // Loopback is requested only by the single qualifying encoding
  function automatic logic loop_req(input logic bist_n, input logic lb_n,
                                    input logic [1:0] sel);
    return (bist_n == 1'b0) && (lb_n == 1'b0) && (tsel_e'(sel) == TSEL_PARLOOP);
  endfunction

endpackage

// File: rtl/deser16_divider.sv
module deser16_divider #(
  parameter int WORD_W = 16
) (
  input  logic clk_bit,
  input  logic rst_n,
  output logic word_clk,
  output logic tick,
  output logic last
);
  localparam int CW   = $clog2(WORD_W);
  localparam int HALF = WORD_W / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // The counter MSB is a flop output, so word_clk is glitch free with 50% duty
  assign word_clk = cnt_q[CW-1];
  assign tick     = (cnt_q == CW'(HALF - 1));
  assign last     = (cnt_q == CW'(WORD_W - 1));
endmodule

// File: rtl/deser16_shifter.sv
module deser16_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              ser_din,
  input  logic              last,
  input  logic              msb_first,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] nxt;
  logic [WORD_W-1:0] nxt_rev;

  assign nxt = {sh_q, ser_din};

  for (genvar i = 0; i < WORD_W; i++) begin : g_rev
    assign nxt_rev[i] = nxt[WORD_W-1-i];
  end

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_o <= '0;
    end else begin
      sh_q <= nxt[WORD_W-2:0];
      if (last) word_o <= msb_first ? nxt : nxt_rev;
    end
  end
endmodule

// File: rtl/deser16_delay.sv
module deser16_delay #(
  parameter int WORD_W = 16,
  parameter int STAGES = 4
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WORD_W-1:0] src;
    if (g == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = st_q[g-1];
    end
    always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)    st_q[g] <= '0;
      else if (tick) st_q[g] <= src;
    end
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/deser16_lb.sv
module deser16_lb #(
  parameter int WORD_W    = 16,
  parameter int LAT_WORDS = 5
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              ser_din,
  input  logic              msb_first,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              bist_en_n,
  input  logic              lpbk_en_n,
  input  logic [1:0]        lpbk_sel,
  output logic [WORD_W-1:0] rx_word,
  output logic              word_clk
);
  import deser16_pkg::*;

  // One stage is the output register itself
  localparam int STAGES = LAT_WORDS - 1;

  logic              tick;
  logic              last;
  logic [WORD_W-1:0] asm_word;
  logic [WORD_W-1:0] dly_word;
  logic              lb_on;

  deser16_divider #(.WORD_W(WORD_W)) div_i (
    .clk_bit (clk_bit),
    .rst_n   (rst_n),
    .word_clk(word_clk),
    .tick    (tick),
    .last    (last)
  );

  deser16_shifter #(.WORD_W(WORD_W)) shf_i (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .ser_din  (ser_din),
    .last     (last),
    .msb_first(msb_first),
    .word_o   (asm_word)
  );

  deser16_delay #(.WORD_W(WORD_W), .STAGES(STAGES)) dly_i (
    .clk_bit(clk_bit),
    .rst_n  (rst_n),
    .tick   (tick),
    .din    (asm_word),
    .dout   (dly_word)
  );

  assign lb_on = loop_req(bist_en_n, lpbk_en_n, lpbk_sel);

  // Source and data are both taken at the word clock rising edge
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n)    rx_word <= '0;
    else if (tick) rx_word <= lb_on ? tx_word : dly_word;
  end
endmodule

// File: rtl/deser16_lb_chk.sv
module deser16_lb_chk #(
  parameter int WORD_W    = 16,
  parameter int LAT_WORDS = 5
) (
  input logic              clk_bit,
  input logic              rst_n,
  input logic [WORD_W-1:0] tx_word,
  input logic              bist_en_n,
  input logic              lpbk_en_n,
  input logic [1:0]        lpbk_sel,
  input logic [WORD_W-1:0] rx_word,
  input logic              word_clk
);
  import deser16_pkg::*;

  localparam int HALF = WORD_W / 2;

  logic       wclk_d;
  logic [7:0] run_q;
  logic [7:0] rises_q;
  logic       lb_seen_q;
  logic       lb_req;

  assign lb_req = loop_req(bist_en_n, lpbk_en_n, lpbk_sel);

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      wclk_d    <= 1'b0;
      run_q     <= '0;
      rises_q   <= '0;
      lb_seen_q <= 1'b0;
    end else begin
      wclk_d <= word_clk;
      run_q  <= (word_clk != wclk_d) ? 8'd1 : run_q + 8'd1;
      if (word_clk && !wclk_d && rises_q != 8'hff) rises_q <= rises_q + 8'd1;
      if (lb_req) lb_seen_q <= 1'b1;
    end
  end

  AST_WCLK_HALF_PERIOD: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (word_clk != wclk_d) |-> (run_q == 8'(HALF))); // R1

  AST_RX_ONLY_ON_RISE: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !$stable(rx_word) |-> $rose(word_clk)); // R4

  AST_LOOP_COPIES_TX: assert property (@(posedge clk_bit) disable iff (!rst_n)
    ($rose(word_clk) && $past(lb_req)) |-> (rx_word == $past(tx_word))); // R6

  AST_ZERO_BEFORE_FIRST: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (rises_q < 8'(LAT_WORDS) && !lb_seen_q && !lb_req) |-> (rx_word == '0)); // R9

  AST_HOLD_MID_WORD: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (!$rose(word_clk) && !$fell(word_clk)) |-> $stable(rx_word)); // R8
endmodule

bind deser16_lb deser16_lb_chk #(.WORD_W(WORD_W), .LAT_WORDS(LAT_WORDS)) chk_i (
  .clk_bit  (clk_bit),
  .rst_n    (rst_n),
  .tx_word  (tx_word),
  .bist_en_n(bist_en_n),
  .lpbk_en_n(lpbk_en_n),
  .lpbk_sel (lpbk_sel),
  .rx_word  (rx_word),
  .word_clk (word_clk)
);

// File: tb/deser16_lb_tb_top.sv
module deser16_lb_tb_top;
  logic        clk_bit = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_din = 1'b0;
  logic        msb_first = 1'b1;
  logic [15:0] tx_word = '0;
  logic        bist_en_n = 1'b1;
  logic        lpbk_en_n = 1'b1;
  logic [1:0]  lpbk_sel = 2'b00;
  logic [15:0] rx_word;
  logic        word_clk;

  int errs = 0;
  int checks = 0;
  int edge_n = -1;
  bit done = 1'b0;

  // {order, word}: order 1 sends bit 15 first, order 0 sends bit 0 first
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 16'h8001}, {1'b0, 16'h8001}, {1'b1, 16'hA5C3}, {1'b0, 16'h3C5A},
    {1'b1, 16'hFFFE}, {1'b0, 16'h0001}, {1'b1, 16'h1234}, {1'b0, 16'hF00D}
  };

  always #4ns clk_bit = ~clk_bit;

  deser16_lb dut_i (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .ser_din  (ser_din),
    .msb_first(msb_first),
    .tx_word  (tx_word),
    .bist_en_n(bist_en_n),
    .lpbk_en_n(lpbk_en_n),
    .lpbk_sel (lpbk_sel),
    .rx_word  (rx_word),
    .word_clk (word_clk)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at edge %0d", req, act, exp, edge_n);
    end
  endtask

  task automatic do_bit(input logic b);
    ser_din = b;
    @(posedge clk_bit);
    edge_n++;
    @(negedge clk_bit);
  endtask

  task automatic send_bits(input logic [15:0] v, input logic order, input int from, input int upto);
    msb_first = order;
    for (int b = from; b < upto; b++) do_bit(order ? v[15-b] : v[b]);
  endtask

  task automatic do_reset();
    @(negedge clk_bit);
    rst_n = 1'b0;
    #1ns;
    chk("R9 rx in reset", rx_word, 16'h0000);
    chk("R9 wclk in reset", {15'd0, word_clk}, 16'h0000);
    repeat (3) @(negedge clk_bit);
    rst_n = 1'b1;
    edge_n = -1;
  endtask

  initial begin
    do_reset();

    // Table walk: groups in both orders, then zero filler to drain the pipe
    for (int w = 0; w < NV + 6; w++) begin
      logic [16:0] v;
      v = (w < NV) ? VEC[w] : 17'h1_0000;
      for (int b = 0; b < 16; b++) begin
        int pos;
        int j;
        logic [15:0] exp;
        msb_first = v[16];
        do_bit(v[16] ? v[15-b] : v[b]);
        pos = edge_n % 16;
        chk("R1 word_clk", {15'd0, word_clk}, {15'd0, (pos >= 7 && pos <= 14)});
        if (pos == 7) begin
          j = edge_n / 16;
          if (j < 5)            exp = 16'h0000;
          else if (j - 5 < NV)  exp = VEC[j-5][15:0];
          else                  exp = 16'h0000;
          if (j < 5)                 chk("R9 zero before first", rx_word, exp);
          else if (VEC[(j-5) % NV][16]) chk("R2 R5 msb-first latency", rx_word, exp);
          else                       chk("R3 R5 lsb-first latency", rx_word, exp);
        end
      end
    end

    // Directed: steady normal data, then control encodings
    do_reset();
    tx_word = 16'h1234;
    for (int w = 0; w < 6; w++) send_bits(16'hA5C3, 1'b1, 0, 16);
    chk("R5 steady normal", rx_word, 16'hA5C3);

    bist_en_n = 1'b1; lpbk_en_n = 1'b0; lpbk_sel = 2'b10;
    send_bits(16'hA5C3, 1'b1, 0, 16);
    chk("R7 bist off ignored", rx_word, 16'hA5C3);
    bist_en_n = 1'b0; lpbk_en_n = 1'b1; lpbk_sel = 2'b10;
    send_bits(16'hA5C3, 1'b1, 0, 16);
    chk("R7 loop enable off ignored", rx_word, 16'hA5C3);
    bist_en_n = 1'b0; lpbk_en_n = 1'b0; lpbk_sel = 2'b11;
    send_bits(16'hA5C3, 1'b1, 0, 16);
    chk("R7 wrong select ignored", rx_word, 16'hA5C3);
    lpbk_sel = 2'b01;
    send_bits(16'hA5C3, 1'b1, 0, 16);
    chk("R7 serial select ignored", rx_word, 16'hA5C3);

    // Enable loopback right after a word clock rise
    send_bits(16'hA5C3, 1'b1, 0, 8);
    lpbk_sel = 2'b10;
    send_bits(16'hA5C3, 1'b1, 8, 12);
    chk("R8 no change mid word", rx_word, 16'hA5C3);
    send_bits(16'hA5C3, 1'b1, 12, 16);
    send_bits(16'hA5C3, 1'b1, 0, 8);
    chk("R6 loopback word", rx_word, 16'h1234);

    tx_word = 16'h8001;
    send_bits(16'hA5C3, 1'b1, 8, 14);
    chk("R8 tx change held", rx_word, 16'h1234);
    send_bits(16'hA5C3, 1'b1, 14, 16);
    send_bits(16'hA5C3, 1'b1, 0, 8);
    chk("R6 loopback bit order", rx_word, 16'h8001);

    // Leave loopback mid word
    lpbk_en_n = 1'b1;
    send_bits(16'hA5C3, 1'b1, 8, 16);
    chk("R8 exit held", rx_word, 16'h8001);
    send_bits(16'hA5C3, 1'b1, 0, 8);
    chk("R7 back to normal", rx_word, 16'hA5C3);

    // Reset in the middle of the stream
    send_bits(16'hA5C3, 1'b1, 8, 11);
    do_reset();
    send_bits(16'hA5C3, 1'b1, 0, 8);
    chk("R9 zero after mid reset", rx_word, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule